// File: doc/BRIEF.md
# Bus Strobe and Device Select Generator

This block sits between a processor bus and a pair of add-on peripherals. It turns the processor's raw control lines into four active-low strobes (memory read, memory write, I/O read, I/O write) and decodes the 16-bit address into a narrow 8-byte window. The window is split into two 4-byte device regions. Each device gets an active-low chip select, formed by combining its region select with the I/O read strobe.

A two-bit mode input picks the bus convention:

- **Mode 0:** separate read and write lines, qualified by one memory-or-I/O line.
- **Mode 1:** separate read and write lines, qualified by separate memory-request and I/O-request lines.
- **Mode 2:** a single read/write line with an address strobe. In this mode the block returns a registered acknowledge to the processor once a selected device has taken write data.

Mode 3 is idle. The strobe and select paths are combinational. Only the acknowledge is clocked.

Top module: `bus_strobe_select`

## Requirements
- R1: In mode 0, a high `mio` marks a memory access and a low `mio` marks an I/O access. `mem_rd_n`/`mem_wr_n` go low only when `rd_n`/`wr_n` is low with `mio` high. `io_rd_n`/`io_wr_n` go low only when `rd_n`/`wr_n` is low with `mio` low. With `rd_n` and `wr_n` both high, every strobe is high.
- R2: In mode 1, a memory strobe is the OR of `mreq_n` with `rd_n` or `wr_n`, and an I/O strobe is the OR of `iorq_n` with `rd_n` or `wr_n`. `mio` is ignored in this mode.
- R3: In mode 2, with `as_n` low, `rw` high gives `mem_rd_n` low and `rw` low gives `mem_wr_n` low. The I/O strobes stay high in this mode, and every strobe is high while `as_n` is high.
- R4: At most one strobe is low at any time. The following all leave every strobe high:
  - `rd_n` and `wr_n` both low (modes 0 and 1);
  - `mreq_n` and `iorq_n` both low (mode 1);
  - mode 3.
- R5: The window is hit only when `addr[15:3]` equals `WIN_BASE[15:3]`. The default base is 0x87F8, giving the window 0x87F8–0x87FF. An address outside the window drives no chip select low.
- R6: Inside the window, `addr[2]` low selects device 0 on `cs_n[0]` (0x87F8–0x87FB), and `addr[2]` high selects device 1 on `cs_n[1]` (0x87FC–0x87FF). At most one chip select is low at any time.
- R7: A chip select is low only while its region is addressed and `io_rd_n` is low. An I/O write or a memory read to the window leaves both chip selects high.
- R8: With `WIN_BASE` set to 0xA7C8, the window moves to 0xA7C8–0xA7CF with the same `addr[2]` split, and 0x87F8 no longer selects a device.
- R9: In mode 2, a cycle with `as_n` low, `rw` low and the address inside the window sets `ack` high at the next rising clock edge. `ack` stays high while that write is held.
- R10: `ack` clears at the clock edge after `as_n` is seen high. A write outside the window, a read, or any access outside mode 2 does not raise `ack`.
- R11: A synchronous active-high `rst` clears `ack` at the next rising edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the acknowledge register |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Bus convention: 0 read/write with memory-or-I/O line, 1 read/write with request lines, 2 read/write line with address strobe, 3 idle |
| addr | input | 16 | Processor address |
| rd_n | input | 1 | Active-low read (modes 0 and 1) |
| wr_n | input | 1 | Active-low write (modes 0 and 1) |
| mio | input | 1 | High for memory, low for I/O (mode 0) |
| mreq_n | input | 1 | Active-low memory request (mode 1) |
| iorq_n | input | 1 | Active-low I/O request (mode 1) |
| rw | input | 1 | High read, low write (mode 2) |
| as_n | input | 1 | Active-low address valid (mode 2) |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| cs_n | output | 2 | Device chip selects, active low; bit 0 lower region, bit 1 upper region |
| ack | output | 1 | Registered write acknowledge to the processor (mode 2) |

## Verification
The address-window decode and the strobe decode act in the same cycle, and a chip select must fall only when both agree. The vector table therefore pairs in-window addresses with every strobe kind, and pairs out-of-window addresses with an I/O read. Each vector is judged at the combinational outputs a moment after the inputs settle.

The acknowledge can see a set condition and a clear condition on neighbouring edges. A directed sequence holds a selected write across two edges and then releases the address strobe. `ack` is sampled at the negative edge after each rising edge.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [1:0] {
    BUS_SPLIT_MIO = 2'd0,
    BUS_SPLIT_REQ = 2'd1,
    BUS_RW_STROBE = 2'd2,
    BUS_OFF       = 2'd3
  } bus_mode_e;

  typedef struct packed {
    logic mem_rd_n;
    logic mem_wr_n;
    logic io_rd_n;
    logic io_wr_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1,
                                      io_rd_n: 1'b1, io_wr_n: 1'b1};

endpackage

// File: rtl/bss_strobe_gen.sv
module bss_strobe_gen
  import bss_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bus_mode_e mode,
  input  logic      rd_n,
  input  logic      wr_n,
  input  logic      mio,
  input  logic      mreq_n,
  input  logic      iorq_n,
  input  logic      rw,
  input  logic      as_n,
  output strobe_t   st
);

  logic dir_clash;
  logic space_clash;

  assign dir_clash   = ~rd_n & ~wr_n;
  assign space_clash = ~mreq_n & ~iorq_n;

  always_comb begin
    st = STROBE_IDLE;
    unique case (mode)
      BUS_SPLIT_MIO: begin
        if (!dir_clash) begin
          st.mem_rd_n = rd_n | ~mio;
          st.mem_wr_n = wr_n | ~mio;
          st.io_rd_n  = rd_n | mio;
          st.io_wr_n  = wr_n | mio;
        end
      end
      BUS_SPLIT_REQ: begin
        if (!dir_clash && !space_clash) begin
          st.mem_rd_n = rd_n | mreq_n;
          st.mem_wr_n = wr_n | mreq_n;
          st.io_rd_n  = rd_n | iorq_n;
          st.io_wr_n  = wr_n | iorq_n;
        end
      end
      BUS_RW_STROBE: begin
        st.mem_rd_n = ~rw | as_n;
        st.mem_wr_n = rw | as_n;
      end
      default: st = STROBE_IDLE;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones(~st) <= 1); // R4
  AST_RW_NO_IO: assert property (@(posedge clk) disable iff (rst)
    (mode == BUS_RW_STROBE) |-> (st.io_rd_n && st.io_wr_n)); // R3
  AST_MIO_MEM_SIDE: assert property (@(posedge clk) disable iff (rst)
    (mode == BUS_SPLIT_MIO && mio) |-> (st.io_rd_n && st.io_wr_n)); // R1
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode == BUS_OFF) |-> (st == STROBE_IDLE)); // R4

endmodule

// File: rtl/bss_addr_decode.sv
module bss_addr_decode #(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_LOG2 = 3,
  parameter int                DEV_LOG2 = 1,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h87F8,
  localparam int               NDEV     = 1 << DEV_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output logic [NDEV-1:0]   dev_sel_n
);

  logic [DEV_LOG2-1:0] region;

  assign win_hit = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign region  = addr[WIN_LOG2-1 -: DEV_LOG2];

  for (genvar g = 0; g < NDEV; g++) begin : g_region
    assign dev_sel_n[g] = ~(win_hit && (region == DEV_LOG2'(g)));
  end

endmodule

// File: rtl/bss_ack_reg.sv
module bss_ack_reg
  import bss_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bus_mode_e mode,
  input  logic      as_n,
  input  logic      rw,
  input  logic      any_sel,
  output logic      ack
);

  logic take_write;

  assign take_write = (mode == BUS_RW_STROBE) && !as_n && !rw && any_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
    end else if (mode != BUS_RW_STROBE || as_n) begin
      ack <= 1'b0;
    end else if (take_write) begin
      ack <= 1'b1;
    end
  end

  AST_ACK_RISE: assert property (@(posedge clk) disable iff (rst)
    take_write |=> ack); // R9
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    as_n |=> !ack); // R10
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(!rw && !as_n && any_sel)); // R10
  AST_ACK_RESET: assert property (@(posedge clk)
    rst |=> !ack); // R11

endmodule

// File: rtl/bus_strobe_select.sv
module bus_strobe_select
  import bss_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_LOG2 = 3,
  parameter int                DEV_LOG2 = 1,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h87F8,
  localparam int               NDEV     = 1 << DEV_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              mio,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rw,
  input  logic              as_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic [NDEV-1:0]   cs_n,
  output logic              ack
);

  bus_mode_e       mode;
  strobe_t         st;
  logic            win_hit;
  logic [NDEV-1:0] dev_sel_n;
  logic            any_sel;

  assign mode    = bus_mode_e'(mode_sel);
  assign any_sel = ~&dev_sel_n;

  bss_strobe_gen u_strobe (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .mio    (mio),
    .mreq_n (mreq_n),
    .iorq_n (iorq_n),
    .rw     (rw),
    .as_n   (as_n),
    .st     (st)
  );

  bss_addr_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .DEV_LOG2 (DEV_LOG2),
    .WIN_BASE (WIN_BASE)
  ) u_decode (
    .addr      (addr),
    .win_hit   (win_hit),
    .dev_sel_n (dev_sel_n)
  );

  bss_ack_reg u_ack (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .as_n    (as_n),
    .rw      (rw),
    .any_sel (any_sel),
    .ack     (ack)
  );

  assign mem_rd_n = st.mem_rd_n;
  assign mem_wr_n = st.mem_wr_n;
  assign io_rd_n  = st.io_rd_n;
  assign io_wr_n  = st.io_wr_n;

  for (genvar g = 0; g < NDEV; g++) begin : g_cs
    assign cs_n[g] = dev_sel_n[g] | st.io_rd_n;
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n)); // R6
  AST_CS_NEEDS_IORD: assert property (@(posedge clk) disable iff (rst)
    (~&cs_n) |-> !io_rd_n); // R7
  AST_CS_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (~&cs_n) |-> win_hit); // R5

endmodule

// File: tb/bus_strobe_select_tb.sv
module bus_strobe_select_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'd0;
  logic [15:0] addr = 16'h0000;
  logic        rd_n = 1'b1, wr_n = 1'b1, mio = 1'b1;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rw = 1'b1, as_n = 1'b1;
  logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, ack;
  logic [1:0]  cs_n;
  logic        mem_rd2_n, mem_wr2_n, io_rd2_n, io_wr2_n, ack2;
  logic [1:0]  cs2_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bus_strobe_select u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rw(rw), .as_n(as_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .cs_n(cs_n), .ack(ack)
  );

  bus_strobe_select #(.WIN_BASE(16'hA7C8)) u_dut2 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rw(rw), .as_n(as_n),
    .mem_rd_n(mem_rd2_n), .mem_wr_n(mem_wr2_n), .io_rd_n(io_rd2_n),
    .io_wr_n(io_wr2_n), .cs_n(cs2_n), .ack(ack2)
  );

  // {mode, addr, rd_n wr_n mio mreq_n iorq_n rw as_n, exp mrd mwr iord iowr, exp cs_n}
  localparam int NVEC = 18;
  localparam logic [30:0] VEC [NVEC] = '{
    {2'd0, 16'h87F8, 7'b0111111, 4'b0111, 2'b11},
    {2'd0, 16'h0000, 7'b1011111, 4'b1011, 2'b11},
    {2'd0, 16'h87F9, 7'b0101111, 4'b1101, 2'b10},
    {2'd0, 16'h87FD, 7'b1001111, 4'b1110, 2'b11},
    {2'd0, 16'h87FE, 7'b0101111, 4'b1101, 2'b01},
    {2'd0, 16'h87F8, 7'b0001111, 4'b1111, 2'b11},
    {2'd1, 16'h87FB, 7'b0111011, 4'b1101, 2'b10},
    {2'd1, 16'h1234, 7'b1010111, 4'b1011, 2'b11},
    {2'd1, 16'h87FF, 7'b0100111, 4'b0111, 2'b11},
    {2'd1, 16'h87FC, 7'b0110011, 4'b1111, 2'b11},
    {2'd1, 16'h87FC, 7'b1111011, 4'b1111, 2'b11},
    {2'd2, 16'h87FC, 7'b0101110, 4'b0111, 2'b11},
    {2'd2, 16'h87F8, 7'b1101000, 4'b1011, 2'b11},
    {2'd2, 16'h87F8, 7'b0101111, 4'b1111, 2'b11},
    {2'd0, 16'h87F0, 7'b0101111, 4'b1101, 2'b11},
    {2'd0, 16'h8FFC, 7'b0101111, 4'b1101, 2'b11},
    {2'd3, 16'h87F8, 7'b0100110, 4'b1111, 2'b11},
    {2'd0, 16'h87F8, 7'b1101111, 4'b1111, 2'b11}
  };
  string vreq [NVEC] = '{"R1", "R1", "R6", "R7", "R6", "R4", "R2", "R2", "R7",
                         "R4", "R2", "R3", "R3", "R3", "R5", "R5", "R4", "R1"};

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [15:0] a, input logic [6:0] ctl);
    mode_sel = m;
    addr     = a;
    {rd_n, wr_n, mio, mreq_n, iorq_n, rw, as_n} = ctl;
  endtask

  initial begin
    #80000;
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "ack after reset", 16'(ack), 16'h0);
    chk("R1", "idle strobes", 16'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 16'hF);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][30:29], VEC[i][28:13], VEC[i][12:6]);
      #1;
      chk(vreq[i], $sformatf("vec %0d strobes", i),
          16'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 16'(VEC[i][5:2]));
      chk(vreq[i], $sformatf("vec %0d cs_n", i), 16'(cs_n), 16'(VEC[i][1:0]));
    end

    // R8: second instance with a relocated window, I/O read in mode 0
    @(negedge clk);
    drive(2'd0, 16'hA7CA, 7'b0101111);
    #1;
    chk("R8", "A7CA cs2_n", 16'(cs2_n), 16'h2);
    chk("R8", "A7CA cs_n default", 16'(cs_n), 16'h3);
    @(negedge clk);
    drive(2'd0, 16'hA7CD, 7'b0101111);
    #1;
    chk("R8", "A7CD cs2_n", 16'(cs2_n), 16'h1);
    @(negedge clk);
    drive(2'd0, 16'h87F8, 7'b0101111);
    #1;
    chk("R8", "87F8 cs2_n", 16'(cs2_n), 16'h3);
    chk("R8", "87F8 cs_n default", 16'(cs_n), 16'h2);

    // R11: reset clears a set acknowledge while the write is held
    @(negedge clk);
    drive(2'd2, 16'h87F8, 7'b1111100);
    @(negedge clk);
    chk("R9", "ack set before reset", 16'(ack), 16'h1);
    rst = 1'b1;
    @(negedge clk);
    chk("R11", "ack cleared by reset", 16'(ack), 16'h0);
    drive(2'd2, 16'h0000, 7'b1111111);
    @(negedge clk);
    rst = 1'b0;

    // R9: rise one edge after a selected write, hold while held
    @(negedge clk);
    drive(2'd2, 16'h87FA, 7'b1111100);
    #1;
    chk("R9", "ack before edge", 16'(ack), 16'h0);
    @(negedge clk);
    chk("R9", "ack after edge", 16'(ack), 16'h1);
    @(negedge clk);
    chk("R9", "ack held", 16'(ack), 16'h1);

    // R10: release of address strobe clears ack
    as_n = 1'b1;
    @(negedge clk);
    chk("R10", "ack after as_n high", 16'(ack), 16'h0);

    // R10: unselected write, read, and mode 0 I/O write leave ack low
    drive(2'd2, 16'h1000, 7'b1111100);
    @(negedge clk);
    chk("R10", "ack unselected write", 16'(ack), 16'h0);
    drive(2'd2, 16'h87FC, 7'b1111110);
    @(negedge clk);
    chk("R10", "ack on read", 16'(ack), 16'h0);
    drive(2'd0, 16'h87F8, 7'b1001100);
    @(negedge clk);
    chk("R10", "ack mode 0 write", 16'(ack), 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule